// File: doc/BRIEF.md
# Systolic Azimuth Correlator Array

This block computes a two-dimensional azimuth correlation over a raster that arrives one complex sample per clock. The raster is organised in columns of `N` samples. Each output pixel is a weighted sum of `2M+1` input samples that share a row position and come from consecutive columns. A chain of `2M+1` identical cells does the work. Each cell keeps its own column of `N` complex coefficients in a recirculating register, and the input samples stream past it. Samples enter at the highest-numbered cell and travel towards cell 0 through an `(N-1)`-sample delay between neighbours. Partial sums start at zero in cell 0 and travel the other way through a single register per cell, so each cell adds one column's weighted contribution. The finished sum leaves the last cell.

A serial port loads the coefficient set. Each strobe on that port shifts one complex coefficient into a chain that threads through every cell. After a full load of `N·(2M+1)` words, rows are counted from the first sample accepted. The finished pixel stream lags the centred correlation by `M·N` sample periods.

Top module: `corr_array`

## Requirements
- R1: A clock edge with `rst` high clears `pix_valid`, `pix_re`, `pix_im`, every coefficient and every stored sample. Samples streamed after reset with no coefficient load therefore give pixels equal to 0.
- R2: Each cycle with `coef_shift` high shifts one coefficient into the chain. A full load is `N·(2M+1)` shifts. The words go in cell by cell, starting with cell 2M and ending with cell 0. Within each cell they go in row order, rows 0 to N-1. The full load replaces the whole set.
- R3: Let n be the index of an accepted sample and n0 the number of samples accepted before the last load. Let r = (n−n0) mod N. Once n−n0 ≥ 2M, the pixel for sample n is the sum over k = 0 to 2M of c_k[r]·x[n−(2M−k)·N], where c_k[r] is row r of cell k's coefficient column. Samples from before reset count as zero.
- R4: Samples and coefficients are signed two's-complement values, 4 bits per component. Each product is computed as real = ar·br − ai·bi and imag = ar·bi + ai·br.
- R5: Accumulation uses 18-bit two's complement per component. With M=2, when every sample and every coefficient is −8−8i, the pixel is 0 + 640i.
- R6: The clock edge that accepts a sample (`smp_valid` high and `coef_shift` low) updates `pix_re` and `pix_im`. `pix_valid` is high for exactly the following cycle.
- R7: In a cycle with both `smp_valid` and `coef_shift` low, nothing changes. `pix_valid` is low, the pixel holds its value, and the coefficient rotation pauses, so rows after the gap continue in sequence.
- R8: In a cycle with `coef_shift` high, any sample presented is discarded. The coefficient shift still happens, `pix_valid` is low, the pixel holds its value, and the discarded sample never appears in any later sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe; advances the array |
| smp_re | input | SW | Sample real part, signed |
| smp_im | input | SW | Sample imaginary part, signed |
| coef_shift | input | 1 | Shifts one coefficient into the chain; has priority over the sample strobe |
| coef_re | input | SW | Coefficient real part, signed |
| coef_im | input | SW | Coefficient imaginary part, signed |
| pix_valid | output | 1 | High for one cycle after each accepted sample |
| pix_re | output | AW | Pixel real part, signed |
| pix_im | output | AW | Pixel imaginary part, signed |

## Verification
A coefficient shift and a sample strobe can arrive in the same cycle. The bench provokes this by raising `smp_valid` together with `coef_shift` on several words in the middle of a load. It judges the outcome three ways. The pixel must not move and `pix_valid` must stay low on that cycle. The load must still finish with the intended word order. The following stream must match a model that never saw the colliding samples. Idle gaps between samples are checked the same way, which shows that the coefficient rotation pauses together with the data path.

// File: rtl/corr_pkg.sv
package corr_pkg;

  // Action broadcast to every cell each clock
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_STEP  = 2'd1,
    ACT_SHIFT = 2'd2
  } cell_act_e;

  localparam int unsigned SMP_W_DEF = 4;
  localparam int unsigned ACC_W_DEF = 18;

  // Read position inside cell k's ring, chosen so that every cell
  // reads the same row for the output sample its product belongs to.
  function automatic int unsigned tap_slot(input int unsigned k,
                                           input int unsigned last,
                                           input int unsigned n);
    return (last - k) % n;
  endfunction

endpackage

// File: rtl/corr_coef_bank.sv
module corr_coef_bank
  import corr_pkg::*;
#(
  parameter int unsigned N  = 4,
  parameter int unsigned K  = 5,
  parameter int unsigned SW = SMP_W_DEF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  cell_act_e            act,
  input  logic signed [SW-1:0] sin_re,
  input  logic signed [SW-1:0] sin_im,
  output logic signed [SW-1:0] tap_re [K],
  output logic signed [SW-1:0] tap_im [K]
);

  localparam int unsigned WW = 2 * SW;

  logic [WW-1:0] ring [K][N];

  // Loading shifts one long chain through all cells; a step rotates
  // each cell's column by one slot.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < K; k++)
        for (int i = 0; i < N; i++)
          ring[k][i] <= '0;
    end else if (act == ACT_SHIFT) begin
      for (int k = 0; k < K; k++)
        for (int i = 0; i < N; i++) begin
          if (i != N - 1)
            ring[k][i] <= ring[k][(i + 1) % N];
          else if (k == 0)
            ring[k][i] <= {sin_re, sin_im};
          else
            ring[k][i] <= ring[(k + K - 1) % K][0];
        end
    end else if (act == ACT_STEP) begin
      for (int k = 0; k < K; k++)
        for (int i = 0; i < N; i++)
          ring[k][i] <= ring[k][(i + 1) % N];
    end
  end

  for (genvar gk = 0; gk < K; gk++) begin : g_tap
    localparam int unsigned TAP = tap_slot(gk, K - 1, N);
    assign tap_re[gk] = ring[gk][TAP][WW-1:SW];
    assign tap_im[gk] = ring[gk][TAP][SW-1:0];
  end

endmodule

// File: rtl/corr_delay.sv
module corr_delay #(
  parameter int unsigned DEPTH = 3,
  parameter int unsigned W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp;

  // Read-before-write circular buffer: the slot about to be written
  // holds the value written DEPTH accepted steps earlier.
  assign dout = mem[wp];

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      for (int i = 0; i < DEPTH; i++)
        mem[i] <= '0;
    end else if (en) begin
      mem[wp] <= din;
      wp      <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
    end
  end

endmodule

// File: rtl/corr_cmul.sv
module corr_cmul #(
  parameter int unsigned SW = 4
) (
  input  logic signed [SW-1:0] a_re,
  input  logic signed [SW-1:0] a_im,
  input  logic signed [SW-1:0] b_re,
  input  logic signed [SW-1:0] b_im,
  output logic signed [2*SW:0] p_re,
  output logic signed [2*SW:0] p_im
);

  localparam int unsigned HW = 2 * SW;

  logic signed [HW-1:0] rr, ii, ri, ir;

  assign rr = a_re * b_re;
  assign ii = a_im * b_im;
  assign ri = a_re * b_im;
  assign ir = a_im * b_re;

  assign p_re = {rr[HW-1], rr} - {ii[HW-1], ii};
  assign p_im = {ri[HW-1], ri} + {ir[HW-1], ir};

endmodule

// File: rtl/corr_cell.sv
module corr_cell #(
  parameter int unsigned SW = 4,
  parameter int unsigned AW = 18
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 step,
  input  logic signed [SW-1:0] d_re,
  input  logic signed [SW-1:0] d_im,
  input  logic signed [SW-1:0] c_re,
  input  logic signed [SW-1:0] c_im,
  input  logic signed [AW-1:0] pin_re,
  input  logic signed [AW-1:0] pin_im,
  output logic signed [AW-1:0] pout_re,
  output logic signed [AW-1:0] pout_im
);

  localparam int unsigned PW = 2 * SW + 1;

  logic signed [PW-1:0] prod_re, prod_im;
  logic signed [AW-1:0] ext_re,  ext_im;

  corr_cmul #(.SW(SW)) u_mul (
    .a_re (d_re),
    .a_im (d_im),
    .b_re (c_re),
    .b_im (c_im),
    .p_re (prod_re),
    .p_im (prod_im)
  );

  assign ext_re = {{(AW-PW){prod_re[PW-1]}}, prod_re};
  assign ext_im = {{(AW-PW){prod_im[PW-1]}}, prod_im};

  always_ff @(posedge clk) begin
    if (rst) begin
      pout_re <= '0;
      pout_im <= '0;
    end else if (step) begin
      pout_re <= pin_re + ext_re;
      pout_im <= pin_im + ext_im;
    end
  end

endmodule

// File: rtl/corr_array.sv
module corr_array
  import corr_pkg::*;
#(
  parameter int unsigned N  = 4,
  parameter int unsigned M  = 2,
  parameter int unsigned SW = SMP_W_DEF,
  parameter int unsigned AW = ACC_W_DEF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_valid,
  input  logic signed [SW-1:0] smp_re,
  input  logic signed [SW-1:0] smp_im,
  input  logic                 coef_shift,
  input  logic signed [SW-1:0] coef_re,
  input  logic signed [SW-1:0] coef_im,
  output logic                 pix_valid,
  output logic signed [AW-1:0] pix_re,
  output logic signed [AW-1:0] pix_im
);

  localparam int unsigned K  = 2 * M + 1;
  localparam int unsigned WW = 2 * SW;
  localparam int unsigned DD = N - 1;

  cell_act_e act;
  logic      step;

  // Loading has priority: a sample offered with a shift is dropped.
  assign act  = coef_shift ? ACT_SHIFT : (smp_valid ? ACT_STEP : ACT_HOLD);
  assign step = (act == ACT_STEP);

  logic signed [SW-1:0] tap_re [K];
  logic signed [SW-1:0] tap_im [K];
  logic [WW-1:0]        dbus   [K];
  logic signed [AW-1:0] ps_re  [K];
  logic signed [AW-1:0] ps_im  [K];

  corr_coef_bank #(.N(N), .K(K), .SW(SW)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .act    (act),
    .sin_re (coef_re),
    .sin_im (coef_im),
    .tap_re (tap_re),
    .tap_im (tap_im)
  );

  // Samples enter the highest cell and move towards cell 0.
  assign dbus[K-1] = {smp_re, smp_im};

  for (genvar gk = 0; gk < K; gk++) begin : g_cell
    logic signed [AW-1:0] pin_re, pin_im;

    if (gk == 0) begin : g_head
      assign pin_re = '0;
      assign pin_im = '0;
    end else begin : g_link
      assign pin_re = ps_re[gk-1];
      assign pin_im = ps_im[gk-1];

      corr_delay #(.DEPTH(DD), .W(WW)) u_dly (
        .clk  (clk),
        .rst  (rst),
        .en   (step),
        .din  (dbus[gk]),
        .dout (dbus[gk-1])
      );
    end

    corr_cell #(.SW(SW), .AW(AW)) u_cell (
      .clk     (clk),
      .rst     (rst),
      .step    (step),
      .d_re    (dbus[gk][WW-1:SW]),
      .d_im    (dbus[gk][SW-1:0]),
      .c_re    (tap_re[gk]),
      .c_im    (tap_im[gk]),
      .pin_re  (pin_re),
      .pin_im  (pin_im),
      .pout_re (ps_re[gk]),
      .pout_im (ps_im[gk])
    );
  end

  assign pix_re = ps_re[K-1];
  assign pix_im = ps_im[K-1];

  always_ff @(posedge clk) begin
    if (rst) pix_valid <= 1'b0;
    else     pix_valid <= step;
  end

endmodule

// File: rtl/corr_array_chk.sv
module corr_array_chk #(
  parameter int unsigned K  = 5,
  parameter int unsigned SW = 4,
  parameter int unsigned AW = 18
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 smp_valid,
  input logic                 coef_shift,
  input logic                 pix_valid,
  input logic signed [AW-1:0] pix_re,
  input logic signed [AW-1:0] pix_im
);

  localparam int BOUND = int'(K) * (1 << (2 * SW - 1));

  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (!pix_valid && pix_re == '0 && pix_im == '0));

  p_accept_flags_r6: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !coef_shift) |=> pix_valid);

  p_idle_holds_r7: assert property (@(posedge clk) disable iff (rst)
    (!smp_valid && !coef_shift) |=> (!pix_valid && $stable(pix_re) && $stable(pix_im)));

  p_shift_discards_r8: assert property (@(posedge clk) disable iff (rst)
    coef_shift |=> (!pix_valid && $stable(pix_re) && $stable(pix_im)));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> (int'(pix_re) <= BOUND && int'(pix_re) >= -BOUND &&
                   int'(pix_im) <= BOUND && int'(pix_im) >= -BOUND));

endmodule

bind corr_array corr_array_chk #(.K(K), .SW(SW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .smp_valid  (smp_valid),
  .coef_shift (coef_shift),
  .pix_valid  (pix_valid),
  .pix_re     (pix_re),
  .pix_im     (pix_im)
);

// File: tb/tb_corr_array.sv
module tb_corr_array;

  localparam int N  = 4;
  localparam int M  = 2;
  localparam int K  = 2 * M + 1;
  localparam int SW = 4;
  localparam int AW = 18;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 smp_valid = 1'b0;
  logic signed [SW-1:0] smp_re = '0, smp_im = '0;
  logic                 coef_shift = 1'b0;
  logic signed [SW-1:0] coef_re = '0, coef_im = '0;
  logic                 pix_valid;
  logic signed [AW-1:0] pix_re, pix_im;

  always #2 clk = ~clk;

  corr_array #(.N(N), .M(M), .SW(SW), .AW(AW)) dut (
    .clk (clk), .rst (rst),
    .smp_valid (smp_valid), .smp_re (smp_re), .smp_im (smp_im),
    .coef_shift (coef_shift), .coef_re (coef_re), .coef_im (coef_im),
    .pix_valid (pix_valid), .pix_re (pix_re), .pix_im (pix_im)
  );

  int checks = 0;
  int errors = 0;
  int xr [0:1023];
  int xi [0:1023];
  int cr [K][N];
  int ci [K][N];
  int nacc = 0;
  int n0   = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input bit v, input bit sh, input int dre, input int dim,
                       input int cre, input int cim);
    smp_valid  = v;   coef_shift = sh;
    smp_re     = SW'(dre); smp_im = SW'(dim);
    coef_re    = SW'(cre); coef_im = SW'(cim);
    @(negedge clk);
  endtask

  task automatic model(input int n, output logic [AW-1:0] er, output logic [AW-1:0] ei);
    int sr = 0, si = 0;
    int r = (n - n0) % N;
    for (int q = 0; q < K; q++) begin
      int idx = n - (2 * M - q) * N;
      if (idx >= 0) begin
        sr += cr[q][r] * xr[idx] - ci[q][r] * xi[idx];
        si += cr[q][r] * xi[idx] + ci[q][r] * xr[idx];
      end
    end
    er = sr[AW-1:0];
    ei = si[AW-1:0];
  endtask

  // Accept one sample and check the resulting pixel (R3, R4, R6)
  task automatic push(input int re, input int im);
    logic [AW-1:0] er, ei;
    xr[nacc] = re; xi[nacc] = im;
    drive(1'b1, 1'b0, re, im, 0, 0);
    chk(pix_valid === 1'b1, "R6", "pix_valid after accept", pix_valid, 1);
    if (nacc - n0 >= 2 * M) begin
      model(nacc, er, ei);
      chk(pix_re === er, "R3", "pixel real", pix_re, $signed(er));
      chk(pix_im === ei, "R4", "pixel imag", pix_im, $signed(ei));
    end
    nacc++;
  endtask

  task automatic idle(input int cycles);
    for (int c = 0; c < cycles; c++) begin
      logic signed [AW-1:0] hr = pix_re, hi = pix_im;
      drive(1'b0, 1'b0, 3, -2, 5, 1);
      chk(pix_valid === 1'b0, "R7", "pix_valid idle", pix_valid, 0);
      chk(pix_re === hr && pix_im === hi, "R7", "pixel held idle", pix_re, hr);
    end
  endtask

  // Full load in the required order; collide_mask marks words offered
  // together with a sample strobe (R2, R8)
  task automatic load(input int mode, input int collide_mask);
    int w = 0;
    for (int q = 0; q < K; q++)
      for (int i = 0; i < N; i++) begin
        if (mode == 0) begin
          cr[q][i] = $urandom_range(0, 15) - 8;
          ci[q][i] = $urandom_range(0, 15) - 8;
        end else begin
          cr[q][i] = -8; ci[q][i] = -8;
        end
      end
    for (int q = K - 1; q >= 0; q--)
      for (int i = 0; i < N; i++) begin
        logic signed [AW-1:0] hr = pix_re, hi = pix_im;
        bit col = (collide_mask >> (w % 32)) & 1;
        drive(col, 1'b1, 7, -8, cr[q][i], ci[q][i]);
        chk(pix_valid === 1'b0, col ? "R8" : "R2", "pix_valid during load", pix_valid, 0);
        chk(pix_re === hr && pix_im === hi, col ? "R8" : "R2",
            "pixel held during load", pix_re, hr);
        w++;
      end
    n0 = nacc;
    drive(1'b0, 1'b0, 0, 0, 0, 0);
  endtask

  task automatic t_reset;
    chk(pix_valid === 1'b0, "R1", "pix_valid in reset", pix_valid, 0);
    chk(pix_re === '0 && pix_im === '0, "R1", "pixel in reset", pix_re, 0);
    for (int s = 0; s < 12; s++) begin
      push($urandom_range(0, 15) - 8, $urandom_range(0, 15) - 8);
      chk(pix_re === '0 && pix_im === '0, "R1", "zero coefficients", pix_re, 0);
    end
    idle(1);
  endtask

  task automatic t_random;
    load(0, 0);
    for (int s = 0; s < 3 * N * K; s++)
      push($urandom_range(0, 15) - 8, $urandom_range(0, 15) - 8);
    idle(1);
  endtask

  task automatic t_extreme;
    load(1, 0);
    for (int s = 0; s < 2 * M * N + 4; s++) push(-8, -8);
    chk(pix_re === '0, "R5", "all -8 real", pix_re, 0);
    chk(pix_im === AW'(640), "R5", "all -8 imag", pix_im, 640);
    load(0, 0);
    for (int s = 0; s < 2 * N * K; s++)
      push(($urandom_range(0, 1) != 0) ? 7 : -8, ($urandom_range(0, 1) != 0) ? 7 : -8);
    idle(1);
  endtask

  task automatic t_gaps;
    load(0, 0);
    for (int s = 0; s < 30; s++) begin
      push($urandom_range(0, 15) - 8, $urandom_range(0, 15) - 8);
      if (s % 3 != 2) idle($urandom_range(1, 3));
    end
  endtask

  task automatic t_collision;
    load(0, 32'h0000_4a09);
    for (int s = 0; s < 2 * N * K; s++)
      push($urandom_range(0, 15) - 8, $urandom_range(0, 15) - 8);
    idle(1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_random();
    t_extreme();
    t_gaps();
    t_collision();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule